// File: doc/BRIEF.md
# Privileged Control Register Bank

This block holds the 64-bit privileged control registers of a processor core. Neighbouring logic reaches them through two index-addressed ports. The read port is purely combinational. The write port commits on the rising clock edge.

Registers do not share one write rule. Each index has its own write mask. Some registers clear when written. One register is set to one by any write. The cycle register merges its stored upper half with a free-running counter when it is read. A group of indices is write-only and another group is read-only. An access in the wrong direction, or to an index that is not implemented, raises a combinational error flag. A write marked speculative is dropped without any effect. A few fields drive dedicated output pins: the interrupt priority level, the current and alternate processor modes, and the cycle-control bit. The reset values of the trap base register and of the core-identifier scratch slot are set by parameters.

Top module: `cpriv_bank`

## Requirements
- R1: After reset every index reads zero, except three. Index 24 (trap base) reads parameter TRAP_BASE_RST, index 25 (memory control) reads 0x6, and index 16 (scratch) reads parameter CORE_ID.
- R2: Scratch indices 0..23, trap base 24 and memory control 25 store all 64 written bits. Exception address 26 stores the written value with bit 1 forced to zero.
- R3: These registers keep only the bits in their mask on write:
  - 27 and 28 (AST request and enable): 0xf
  - 29 (priority level): 0x1f
  - 33 (software interrupt): 0x7fff0
  - 34 (instruction control): 0xffffff0300
  - 35 and 36 (page-table bases): 0xffffffffc0000000
  - 37 (data-cache test): 0x1ffb
  - 38 and 39 (cache and miss-file modes): 0x3f
  - 40 (instruction ASN): 0x7f0
  - 41 (data ASN): 0xfe00000000000000
- R4: Mode registers 30 (current) and 31 (data-side current) keep only mask 0x18. Index 32 (alternate mode) is write-only with mask 0x18. ipl_o shows bits 4:0 of index 29, cur_mode_o shows bits 4:3 of index 30, and alt_mode_o shows bits 4:3 of index 32.
- R5: Any write to index 42 (exception summary) or 43 (exception mask) leaves it zero, whatever the data.
- R6: A read of index 44 returns the stored bits 63:32 above the low 32 bits of a counter that advances by one every clock. A write to index 44 stores all 64 bits.
- R7: Any write to index 45 (cycle control) makes it read 1, and cyc_run_o goes to 1. Later writes keep it at 1.
- R8: Reading a write-only index (32, or 46..53) raises acc_err. Writing a read-only index (54..58) raises acc_err. Read-only indices read zero. Write-only indices read zero, and writing them raises no error.
- R9: Indices 59..63 raise acc_err on both read and write, read zero, and a write to them changes nothing.
- R10: A write with wr_spec high changes no register and raises no error.
- R11: rd_data and acc_err follow the indices combinationally. A write becomes visible only after the rising edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read access qualifier (for error checking) |
| rd_idx | input | 6 | Read index |
| rd_data | output | 64 | Read data |
| wr_en | input | 1 | Write request |
| wr_spec | input | 1 | Marks the write as speculative (suppressed) |
| wr_idx | input | 6 | Write index |
| wr_data | input | 64 | Write data |
| acc_err | output | 1 | Wrong-direction or unimplemented access |
| ipl_o | output | 5 | Interrupt priority level field |
| cur_mode_o | output | 2 | Current processor mode field |
| alt_mode_o | output | 2 | Alternate processor mode field |
| cyc_run_o | output | 1 | Cycle-control bit |

## Verification
The hardest cases to reach from the ports involve registers that cannot be read back. The write-only alternate-mode register and the clear-on-write summary registers show nothing on rd_data. The bench covers them by sweeping every index with several data patterns and watching the dedicated mode pins and the all-zero readback. Speculative suppression is shown by writing a distinct pattern with wr_spec to all 64 indices and confirming that the full model is unchanged. The free-running low half of the cycle register cannot be predicted in absolute terms, so the bench checks the difference between two reads taken a known number of cycles apart.

// File: rtl/ipr_bank_pkg.sv
package ipr_bank_pkg;
  localparam int unsigned DW       = 64;
  localparam int unsigned IW       = 6;
  localparam int unsigned NSLOT    = 1 << IW;
  localparam int unsigned CYC_LO_W = 32;

  localparam int unsigned IX_CORE_ID  = 16;
  localparam int unsigned IX_TRAP     = 24;
  localparam int unsigned IX_MEMCTL   = 25;
  localparam int unsigned IX_IPL      = 29;
  localparam int unsigned IX_CUR_MODE = 30;
  localparam int unsigned IX_ALT_MODE = 32;
  localparam int unsigned IX_CYC      = 44;
  localparam int unsigned IX_CYC_CTL  = 45;

  typedef enum logic [1:0] {K_NONE, K_RW, K_RO, K_WO} acc_kind_e;
  typedef enum logic [1:0] {W_MASK, W_CLEAR, W_SET1}  wr_rule_e;

  typedef struct packed {
    acc_kind_e       kind;
    wr_rule_e        rule;
    logic            stored;
    logic [DW-1:0]   mask;
  } slot_attr_t;

  function automatic slot_attr_t slot_attr(input logic [IW-1:0] ix);
    slot_attr_t a;
    int i;
    i        = int'(ix);
    a.kind   = K_NONE;
    a.rule   = W_MASK;
    a.stored = 1'b0;
    a.mask   = '0;
    if (i < 26) begin
      a.kind = K_RW; a.stored = 1'b1; a.mask = '1;
    end else begin
      case (i)
        26:      begin a.kind = K_RW; a.stored = 1'b1; a.mask = ~64'h2; end
        27, 28:  begin a.kind = K_RW; a.stored = 1'b1; a.mask = 64'hf; end
        29:      begin a.kind = K_RW; a.stored = 1'b1; a.mask = 64'h1f; end
        30, 31:  begin a.kind = K_RW; a.stored = 1'b1; a.mask = 64'h18; end
        32:      begin a.kind = K_WO; a.stored = 1'b1; a.mask = 64'h18; end
        33:      begin a.kind = K_RW; a.stored = 1'b1; a.mask = 64'h7fff0; end
        34:      begin a.kind = K_RW; a.stored = 1'b1; a.mask = 64'h0000_00ff_ffff_0300; end
        35, 36:  begin a.kind = K_RW; a.stored = 1'b1; a.mask = 64'hffff_ffff_c000_0000; end
        37:      begin a.kind = K_RW; a.stored = 1'b1; a.mask = 64'h1ffb; end
        38, 39:  begin a.kind = K_RW; a.stored = 1'b1; a.mask = 64'h3f; end
        40:      begin a.kind = K_RW; a.stored = 1'b1; a.mask = 64'h7f0; end
        41:      begin a.kind = K_RW; a.stored = 1'b1; a.mask = 64'hfe00_0000_0000_0000; end
        42, 43:  begin a.kind = K_RW; a.stored = 1'b1; a.rule = W_CLEAR; end
        44:      begin a.kind = K_RW; a.stored = 1'b1; a.mask = '1; end
        45:      begin a.kind = K_RW; a.stored = 1'b1; a.rule = W_SET1; a.mask = 64'h1; end
        46, 47, 48, 49, 50, 51, 52, 53: a.kind = K_WO;
        54, 55, 56, 57, 58:             a.kind = K_RO;
        default:                        a.kind = K_NONE;
      endcase
    end
    return a;
  endfunction

  function automatic logic [DW-1:0] slot_reset(input logic [IW-1:0] ix,
                                               input logic [DW-1:0] trap_rst,
                                               input logic [DW-1:0] core_id);
    case (int'(ix))
      IX_CORE_ID: return core_id;
      IX_TRAP:    return trap_rst;
      IX_MEMCTL:  return 64'h6;
      default:    return '0;
    endcase
  endfunction
endpackage

// File: rtl/ipr_slot.sv
module ipr_slot
  import ipr_bank_pkg::*;
#(
  parameter logic [DW-1:0] MASK    = '1,
  parameter logic [DW-1:0] RST_VAL = '0,
  parameter wr_rule_e      RULE    = W_MASK
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  logic [DW-1:0] q_nx;

  always_comb begin
    q_nx = q;
    if (we) begin
      case (RULE)
        W_CLEAR: q_nx = '0;
        W_SET1:  q_nx = DW'(1);
        default: q_nx = wdata & MASK;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST_VAL;
    else if (we) q <= q_nx;
  end

  if (RULE == W_MASK) begin : g_chk_mask
    assert_in_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (q & ~MASK) == '0);
  end else if (RULE == W_CLEAR) begin : g_chk_clear
    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (q == '0));
  end else begin : g_chk_set
    assert_oneshot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (q == DW'(1)) |=> (q == DW'(1)));
  end
endmodule

// File: rtl/ipr_free_ctr.sv
module ipr_free_ctr #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nx;

  always_comb q_nx = q + W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nx;
  end

  assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (q == $past(q) + W'(1)));
endmodule

// File: rtl/ipr_guard.sv
module ipr_guard
  import ipr_bank_pkg::*;
(
  input  logic          rd_en,
  input  logic [IW-1:0] rd_idx,
  input  logic          wr_en,
  input  logic          wr_spec,
  input  logic [IW-1:0] wr_idx,
  output logic          rd_err,
  output logic          wr_err,
  output logic          wr_commit
);
  slot_attr_t ra, wa;
  logic       wr_live;

  always_comb begin
    ra        = slot_attr(rd_idx);
    wa        = slot_attr(wr_idx);
    wr_live   = wr_en && !wr_spec;
    rd_err    = rd_en && (ra.kind == K_WO || ra.kind == K_NONE);
    wr_err    = wr_live && (wa.kind == K_RO || wa.kind == K_NONE);
    wr_commit = wr_live && (wa.kind == K_RW || wa.kind == K_WO);
  end
endmodule

// File: rtl/cpriv_bank.sv
module cpriv_bank
  import ipr_bank_pkg::*;
#(
  parameter logic [DW-1:0] TRAP_BASE_RST = 64'h0000_0000_0040_0000,
  parameter logic [DW-1:0] CORE_ID       = 64'd5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic          wr_spec,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  output logic          acc_err,
  output logic [4:0]    ipl_o,
  output logic [1:0]    cur_mode_o,
  output logic [1:0]    alt_mode_o,
  output logic          cyc_run_o
);
  logic [1:0]                   rst_sync_q;
  logic                         rst_n_int;
  logic                         rd_err, wr_err, wr_commit;
  logic [NSLOT-1:0][DW-1:0]     slot_q;
  logic [CYC_LO_W-1:0]          ctr_q;
  slot_attr_t                   rd_attr;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  ipr_guard u_guard (
    .rd_en     (rd_en),
    .rd_idx    (rd_idx),
    .wr_en     (wr_en),
    .wr_spec   (wr_spec),
    .wr_idx    (wr_idx),
    .rd_err    (rd_err),
    .wr_err    (wr_err),
    .wr_commit (wr_commit)
  );

  ipr_free_ctr #(.W(CYC_LO_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n_int),
    .q     (ctr_q)
  );

  for (genvar gi = 0; gi < NSLOT; gi++) begin : g_slot
    localparam slot_attr_t SA = slot_attr(IW'(gi));
    if (SA.stored) begin : g_reg
      logic we_g;
      assign we_g = wr_commit && (wr_idx == IW'(gi));
      ipr_slot #(
        .MASK    (SA.mask),
        .RST_VAL (slot_reset(IW'(gi), TRAP_BASE_RST, CORE_ID)),
        .RULE    (SA.rule)
      ) u_slot (
        .clk   (clk),
        .rst_n (rst_n_int),
        .we    (we_g),
        .wdata (wr_data),
        .q     (slot_q[gi])
      );
    end else begin : g_const
      assign slot_q[gi] = '0;
    end
  end

  always_comb begin
    rd_attr = slot_attr(rd_idx);
    rd_data = '0;
    if (rd_attr.kind == K_RW) begin
      rd_data = slot_q[rd_idx];
      if (rd_idx == IW'(IX_CYC)) rd_data[CYC_LO_W-1:0] = ctr_q;
    end
  end

  assign acc_err    = rd_err || wr_err;
  assign ipl_o      = slot_q[IX_IPL][4:0];
  assign cur_mode_o = slot_q[IX_CUR_MODE][4:3];
  assign alt_mode_o = slot_q[IX_ALT_MODE][4:3];
  assign cyc_run_o  = slot_q[IX_CYC_CTL][0];

  assert_spec_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n_int)
    (wr_en && wr_spec) |=> $stable(slot_q));

  assert_spec_noerr_R10: assert property (@(posedge clk) disable iff (!rst_n_int)
    (wr_en && wr_spec && !rd_en) |-> !acc_err);

  assert_err_nochange_R9: assert property (@(posedge clk) disable iff (!rst_n_int)
    (acc_err && wr_en && !wr_spec && !rd_en) |=> $stable(slot_q));

  assert_err_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n_int)
    (acc_err && rd_en && !wr_en) |-> (rd_data == '0));
endmodule

// File: tb/cpriv_bank_tb.sv
module cpriv_bank_tb;
  localparam logic [63:0] TB_TRAP = 64'h0000_0000_0001_8000;
  localparam logic [63:0] TB_CID  = 64'd3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rd_en, wr_en, wr_spec;
  logic [5:0]  rd_idx, wr_idx;
  logic [63:0] rd_data, wr_data;
  logic        acc_err;
  logic [4:0]  ipl_o;
  logic [1:0]  cur_mode_o, alt_mode_o;
  logic        cyc_run_o;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;
  logic [63:0] exp_q [64];
  logic [1:0]  alt_exp;

  always #2 clk = ~clk;

  cpriv_bank #(.TRAP_BASE_RST(TB_TRAP), .CORE_ID(TB_CID)) u_dut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data),
    .wr_en(wr_en), .wr_spec(wr_spec), .wr_idx(wr_idx), .wr_data(wr_data),
    .acc_err(acc_err), .ipl_o(ipl_o), .cur_mode_o(cur_mode_o),
    .alt_mode_o(alt_mode_o), .cyc_run_o(cyc_run_o)
  );

  // 0 none, 1 read/write, 2 read-only, 3 write-only
  function automatic int kind_of(int ix);
    if (ix < 32) return 1;
    if (ix == 32) return 3;
    if (ix <= 45) return 1;
    if (ix <= 53) return 3;
    if (ix <= 58) return 2;
    return 0;
  endfunction

  function automatic logic [63:0] mask_of(int ix);
    if (ix <= 25) return '1;
    case (ix)
      26: return ~64'h2;
      27, 28: return 64'hf;
      29: return 64'h1f;
      30, 31, 32: return 64'h18;
      33: return 64'h7fff0;
      34: return 64'h0000_00ff_ffff_0300;
      35, 36: return 64'hffff_ffff_c000_0000;
      37: return 64'h1ffb;
      38, 39: return 64'h3f;
      40: return 64'h7f0;
      41: return 64'hfe00_0000_0000_0000;
      44: return '1;
      default: return '0;
    endcase
  endfunction

  function automatic string req_of(int ix);
    if (ix <= 26) return "R2";
    if (ix == 30 || ix == 31 || ix == 32) return "R4";
    if (ix <= 41) return "R3";
    if (ix <= 43) return "R5";
    if (ix == 44) return "R6";
    if (ix == 45) return "R7";
    if (ix <= 58) return "R8";
    return "R9";
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exv);
    nchk++;
    if (act !== exv) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exv);
    end
  endtask

  task automatic model_write(int ix, logic [63:0] v);
    if (ix == 32) alt_exp = v[4:3];
    else if (ix == 42 || ix == 43) exp_q[ix] = '0;
    else if (ix == 45) exp_q[ix] = 64'd1;
    else if (kind_of(ix) == 1) exp_q[ix] = v & mask_of(ix);
  endtask

  task automatic write_ix(int ix, logic [63:0] v, bit spec, string tag);
    int k;
    string rq;
    k  = kind_of(ix);
    rq = (tag == "") ? req_of(ix) : tag;
    @(negedge clk);
    rd_en = 0; rd_idx = 6'(ix);
    wr_en = 1; wr_spec = spec; wr_idx = 6'(ix); wr_data = v;
    #1;
    chk(rq, $sformatf("write err idx %0d", ix), {63'd0, acc_err},
        {63'd0, (!spec && (k == 2 || k == 0))});
    if (k == 1 && ix != 44)
      chk("R11", $sformatf("pre-edge value idx %0d", ix), rd_data, exp_q[ix]);
    @(posedge clk);
    if (!spec) model_write(ix, v);
    #1 wr_en = 0;
  endtask

  task automatic read_check(int ix, string tag);
    int k;
    string rq;
    logic [63:0] ev;
    k  = kind_of(ix);
    rq = (tag == "") ? req_of(ix) : tag;
    @(negedge clk);
    wr_en = 0; rd_en = 1; rd_idx = 6'(ix);
    #1;
    ev = (k == 1) ? exp_q[ix] : 64'd0;
    if (ix == 44)
      chk(rq, "cycle upper half", {32'd0, rd_data[63:32]}, {32'd0, ev[63:32]});
    else
      chk(rq, $sformatf("read idx %0d", ix), rd_data, ev);
    chk(rq, $sformatf("read err idx %0d", ix), {63'd0, acc_err},
        {63'd0, (k == 3 || k == 0)});
    rd_en = 0;
  endtask

  task automatic check_all(string tag);
    for (int ix = 0; ix < 64; ix++) read_check(ix, tag);
    chk((tag == "") ? "R4" : tag, "ipl_o",      {59'd0, ipl_o},      {59'd0, exp_q[29][4:0]});
    chk((tag == "") ? "R4" : tag, "cur_mode_o", {62'd0, cur_mode_o}, {62'd0, exp_q[30][4:3]});
    chk((tag == "") ? "R4" : tag, "alt_mode_o", {62'd0, alt_mode_o}, {62'd0, alt_exp});
    chk((tag == "") ? "R7" : tag, "cyc_run_o",  {63'd0, cyc_run_o},  {63'd0, exp_q[45][0]});
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL R11 watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    logic [63:0] pats [3];
    logic [31:0] a, b;
    rst_n = 0; rd_en = 0; wr_en = 0; wr_spec = 0;
    rd_idx = '0; wr_idx = '0; wr_data = '0;
    for (int ix = 0; ix < 64; ix++) exp_q[ix] = '0;
    exp_q[16] = TB_CID; exp_q[24] = TB_TRAP; exp_q[25] = 64'h6;
    alt_exp = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    check_all("R1");

    pats[0] = '1;
    pats[1] = 64'hA5C3_5A3C_9669_0FF0;
    pats[2] = 64'h0;
    for (int p = 0; p < 3; p++) begin
      for (int ix = 0; ix < 64; ix++)
        write_ix(ix, pats[p] ^ (64'h0001_0203_0405_0607 * 64'(ix)), 1'b0, "");
      check_all("");
    end

    // a further nonzero pass so mode and level fields move again
    for (int ix = 0; ix < 64; ix++)
      write_ix(ix, 64'h3C5A_F00F_1234_5678 + 64'(ix * 8), 1'b0, "");
    check_all("");

    // speculative writes must leave everything unchanged
    for (int ix = 0; ix < 64; ix++)
      write_ix(ix, ~exp_q[ix] ^ 64'h18, 1'b1, "R10");
    check_all("R10");

    // low half of cycle register advances once per clock
    @(negedge clk);
    rd_en = 1; rd_idx = 6'd44;
    #1 a = rd_data[31:0];
    repeat (7) @(negedge clk);
    #1 b = rd_data[31:0];
    chk("R6", "cycle delta 7", {32'd0, b - a}, 64'd7);
    @(negedge clk);
    #1 a = rd_data[31:0];
    chk("R6", "cycle delta 1", {32'd0, a - b}, 64'd1);
    rd_en = 0;

    finish_run();
  end
endmodule